// File: doc/BRIEF.md
# Adapter Setup-Bus Option Register Decoder

This block sits behind the setup-bus port of an add-in adapter. Eight option bytes hold the adapter's configuration: the host writes them through a small port window, and the block turns them into the settings the rest of the adapter uses. It holds a fixed identification byte, accepts byte writes at the upper six offsets, and decodes the stored bytes into four settings: a 4-byte I/O window base, an interrupt number, a DMA channel and the base of a 16 KB ROM window. Two comparators tell the adapter when a host I/O address or memory address falls inside its assigned windows.

Decoding happens only while the card-enable bit is set. With the bit clear, the last decoded settings stay in place. Any accepted write can leave the I/O base, interrupt and DMA channel all non-zero. When that happens, the block starts a timed hard reset: a self-test flag rises, an idle flag falls, and both return after a programmable number of cycles. Another qualifying write during the interval starts the count again.

Top module: `pos_cfg_decoder`

## Requirements
- R1: Writes at offsets 0 and 1 change no stored byte and start no reset. A write at offsets 2 to 7 stores the byte at that index. Any byte can be read back combinationally through the read index.
- R2: Offset 0 always reads back 0x1F. Offset 1 always reads back 0x00.
- R3: Settings are decoded during an accepted write only if bit 0 of byte 2 is 1 once that write has been applied. Otherwise the I/O base, interrupt, DMA channel and ROM base all keep their earlier values.
- R4: The I/O base comes from byte 3 ANDed with 0xC7. The mapping is 0x01→0x130, 0x02→0x230, 0x03→0x330, 0x41→0x134, 0x42→0x234 and 0x43→0x334. Every other masked value gives base 0.
- R5: The interrupt number is 8 plus bits 2:0 of byte 4. The DMA channel is bits 3:0 of byte 5.
- R6: When bit 7 of byte 2 is 1, the ROM base is 0. Otherwise bits 5:3 of byte 3 choose the ROM base, from 2→0xC8000 up to 7→0xDC000 in steps of 0x4000. Codes 0 and 1 keep the previous ROM base.
- R7: io_hit is 1 exactly when the I/O base is non-zero and io_addr lies in the range base to base+3.
- R8: rom_hit is 1 exactly when the ROM base is non-zero and mem_addr lies in the range base to base+0x3FFF.
- R9: An accepted write can leave the I/O base, interrupt and DMA channel all non-zero. From the next cycle, stat_selftest is then 1 and stat_idle is 0.
- R10: stat_selftest stays 1 for exactly RESET_CYCLES cycles after the last qualifying write, and is then 0 with stat_idle 1. A qualifying write during the interval restarts the count. The two flags are never equal.
- R11: After reset, all decoded settings are 0, bytes 2 to 7 are 0, stat_selftest is 0 and stat_idle is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Write offset |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 3 | Read index |
| rd_data | output | 8 | Stored byte at rd_addr |
| io_addr | input | 16 | Host I/O address to compare |
| io_hit | output | 1 | io_addr is inside the I/O window |
| mem_addr | input | 20 | Host memory address to compare |
| rom_hit | output | 1 | mem_addr is inside the ROM window |
| io_base | output | 16 | Decoded I/O base (0 = unassigned) |
| irq_num | output | 4 | Decoded interrupt number |
| dma_chan | output | 4 | Decoded DMA channel |
| rom_base | output | 20 | Decoded ROM base (0 = disabled) |
| stat_selftest | output | 1 | Hard reset in progress |
| stat_idle | output | 1 | Adapter idle |

## Verification
The hardest case to reach is a qualifying write that lands while a hard-reset interval is already running. The count has to restart and not finish early. The bench covers this with directed writes placed mid-interval, and it checks the flag one cycle before and one cycle after the exact end of the restarted interval. Random writes are spaced two cycles apart, far shorter than the interval, so they keep re-arming the timer. Random idle gaps let some intervals run to completion. A second hard case is held state: writes with the card-enable bit clear must leave the decoded settings untouched, and yet they can still start a reset from those held values. Directed sequences clear the enable bit between writes to byte 3 to reach this case.

// File: rtl/pos_cfg_pkg.sv
`timescale 1ns/1ps
package pos_cfg_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_REGS   = 8;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int IO_W       = 16;
  localparam int MEM_W      = 20;
  localparam int IRQ_W      = 4;
  localparam int DMA_W      = 4;
  localparam int IO_SPAN_W  = 2;   // 4-byte I/O window
  localparam int ROM_SPAN_W = 14;  // 16 KB ROM window
  localparam int FIRST_WR   = 2;   // lowest writable offset

  localparam int IDX_CTRL = 2;
  localparam int IDX_SEL  = 3;
  localparam int IDX_IRQ  = 4;
  localparam int IDX_DMA  = 5;
  localparam int BIT_CARD_EN = 0;
  localparam int BIT_ROM_OFF = 7;

  localparam logic [BYTE_W-1:0] ADAPTER_ID = 8'h1F;

  // Masked select: bit7 and bit2 must be 0 and bits 1:0 non-zero.
  function automatic logic [IO_W-1:0] io_base_of(input logic [BYTE_W-1:0] sel);
    logic [IO_W-1:0] b;
    b = '0;
    if (!sel[7] && !sel[2] && sel[1:0] != 2'b00)
      b = {6'd0, sel[1:0], 8'h30} + (sel[6] ? 16'h0004 : 16'h0000);
    return b;
  endfunction

  function automatic logic rom_code_ok(input logic [2:0] code);
    return code >= 3'd2;
  endfunction

  function automatic logic [MEM_W-1:0] rom_base_of(input logic [2:0] code);
    return {3'b000, code, 14'd0} + 20'hC0000;
  endfunction

  function automatic logic [IRQ_W-1:0] irq_of(input logic [2:0] low);
    return {1'b1, low};
  endfunction

  function automatic logic io_in_window(input logic [IO_W-1:0] a,
                                        input logic [IO_W-1:0] base);
    return (base != '0) && (a[IO_W-1:IO_SPAN_W] == base[IO_W-1:IO_SPAN_W]);
  endfunction

  function automatic logic rom_in_window(input logic [MEM_W-1:0] a,
                                         input logic [MEM_W-1:0] base);
    return (base != '0) && (a[MEM_W-1:ROM_SPAN_W] == base[MEM_W-1:ROM_SPAN_W]);
  endfunction
endpackage

// File: rtl/pos_regfile.sv
`timescale 1ns/1ps
module pos_regfile
  import pos_cfg_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_addr,
  input  logic [BYTE_W-1:0]                  wr_data,
  input  logic [IDX_W-1:0]                   rd_addr,
  output logic [BYTE_W-1:0]                  rd_data,
  output logic                               wr_take,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]    regs_nxt
);
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_q;

  assign wr_take = wr_en && (int'(wr_addr) >= FIRST_WR);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i < FIRST_WR) begin : g_fixed
      assign regs_q[i]   = (i == 0) ? ADAPTER_ID : '0;
      assign regs_nxt[i] = regs_q[i];
    end else begin : g_rw
      logic hit;
      assign hit         = wr_take && (wr_addr == IDX_W'(i));
      assign regs_nxt[i] = hit ? wr_data : regs_q[i];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[i] <= '0;
        else        regs_q[i] <= regs_nxt[i];
      end
    end
  end

  assign rd_data = regs_q[rd_addr];
endmodule

// File: rtl/pos_decode.sv
`timescale 1ns/1ps
module pos_decode
  import pos_cfg_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_take,
  input  logic [NUM_REGS-1:0][BYTE_W-1:0]    regs_nxt,
  output logic [IO_W-1:0]                    io_base,
  output logic [IRQ_W-1:0]                   irq_num,
  output logic [DMA_W-1:0]                   dma_chan,
  output logic [MEM_W-1:0]                   rom_base,
  output logic                               dec_update,
  output logic                               cfg_ready
);
  logic [BYTE_W-1:0] ctrl_b, sel_b, irq_b, dma_b;
  logic [IO_W-1:0]   base_d;
  logic [IRQ_W-1:0]  irq_d;
  logic [DMA_W-1:0]  dma_d;
  logic [MEM_W-1:0]  rom_d;
  logic [2:0]        rom_code;

  assign ctrl_b   = regs_nxt[IDX_CTRL];
  assign sel_b    = regs_nxt[IDX_SEL];
  assign irq_b    = regs_nxt[IDX_IRQ];
  assign dma_b    = regs_nxt[IDX_DMA];
  assign rom_code = sel_b[5:3];

  assign dec_update = wr_take && ctrl_b[BIT_CARD_EN];

  always_comb begin
    base_d = io_base;
    irq_d  = irq_num;
    dma_d  = dma_chan;
    rom_d  = rom_base;
    if (dec_update) begin
      base_d = io_base_of(sel_b & 8'hC7);
      irq_d  = irq_of(irq_b[2:0]);
      dma_d  = dma_b[DMA_W-1:0];
      if (ctrl_b[BIT_ROM_OFF])     rom_d = '0;
      else if (rom_code_ok(rom_code)) rom_d = rom_base_of(rom_code);
    end
  end

  assign cfg_ready = wr_take && (base_d != '0) && (irq_d != '0) && (dma_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_base  <= '0;
      irq_num  <= '0;
      dma_chan <= '0;
      rom_base <= '0;
    end else begin
      io_base  <= base_d;
      irq_num  <= irq_d;
      dma_chan <= dma_d;
      rom_base <= rom_d;
    end
  end
endmodule

// File: rtl/pos_reset_timer.sv
`timescale 1ns/1ps
module pos_reset_timer #(
  parameter int RESET_CYCLES = 625_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic selftest,
  output logic idle,
  output logic done
);
  localparam int CNT_W = $clog2(RESET_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CNT_W'(RESET_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign selftest = (cnt != '0);
  assign idle     = ~selftest;
  assign done     = (cnt == CNT_W'(1)) && !start;
endmodule

// File: rtl/pos_cfg_decoder.sv
`timescale 1ns/1ps
module pos_cfg_decoder
  import pos_cfg_pkg::*;
#(
  parameter int RESET_CYCLES = 625_000  // 5 ms at 125 MHz
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [2:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic [15:0]       io_addr,
  output logic              io_hit,
  input  logic [19:0]       mem_addr,
  output logic              rom_hit,
  output logic [15:0]       io_base,
  output logic [3:0]        irq_num,
  output logic [3:0]        dma_chan,
  output logic [19:0]       rom_base,
  output logic              stat_selftest,
  output logic              stat_idle
);
  logic                            wr_take;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_nxt;
  logic                            dec_update;
  logic                            cfg_ready;
  logic                            reset_done;

  pos_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .wr_take  (wr_take),
    .regs_nxt (regs_nxt)
  );

  pos_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_take    (wr_take),
    .regs_nxt   (regs_nxt),
    .io_base    (io_base),
    .irq_num    (irq_num),
    .dma_chan   (dma_chan),
    .rom_base   (rom_base),
    .dec_update (dec_update),
    .cfg_ready  (cfg_ready)
  );

  pos_reset_timer #(.RESET_CYCLES(RESET_CYCLES)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cfg_ready),
    .selftest (stat_selftest),
    .idle     (stat_idle),
    .done     (reset_done)
  );

  assign io_hit  = io_in_window(io_addr, io_base);
  assign rom_hit = rom_in_window(mem_addr, rom_base);
endmodule

// File: rtl/pos_cfg_checker.sv
`timescale 1ns/1ps
module pos_cfg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic        io_hit,
  input logic        rom_hit,
  input logic [15:0] io_base,
  input logic [3:0]  irq_num,
  input logic [3:0]  dma_chan,
  input logic [19:0] rom_base,
  input logic        stat_selftest,
  input logic        stat_idle,
  input logic        dec_update,
  input logic        cfg_ready,
  input logic        reset_done
);
  a_r1_low_offsets_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr < 3'd2) |-> !cfg_ready);

  a_r3_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_update |=> ($stable(io_base) && $stable(irq_num) && $stable(dma_chan) && $stable(rom_base)));

  a_r4_base_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (io_base == 16'h0) || (io_base == 16'h130) || (io_base == 16'h230) || (io_base == 16'h330) ||
    (io_base == 16'h134) || (io_base == 16'h234) || (io_base == 16'h334));

  a_r5_irq_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_num == 4'd0) || irq_num[3]);

  a_r7_io_hit_needs_base: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (io_base != 16'h0));

  a_r8_rom_hit_needs_base: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |-> (rom_base != 20'h0));

  a_r9_start_raises_selftest: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> (stat_selftest && !stat_idle));

  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    stat_selftest != stat_idle);

  a_r10_done_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_done |=> (stat_idle && !stat_selftest));
endmodule

bind pos_cfg_decoder pos_cfg_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .io_hit        (io_hit),
  .rom_hit       (rom_hit),
  .io_base       (io_base),
  .irq_num       (irq_num),
  .dma_chan      (dma_chan),
  .rom_base      (rom_base),
  .stat_selftest (stat_selftest),
  .stat_idle     (stat_idle),
  .dec_update    (dec_update),
  .cfg_ready     (cfg_ready),
  .reset_done    (reset_done)
);

// File: tb/tb_pos_cfg_decoder.sv
`timescale 1ns/1ps
module tb_pos_cfg_decoder;
  localparam int N = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [15:0] io_addr = '0;
  logic        io_hit;
  logic [19:0] mem_addr = '0;
  logic        rom_hit;
  logic [15:0] io_base;
  logic [3:0]  irq_num, dma_chan;
  logic [19:0] rom_base;
  logic        stat_selftest, stat_idle;

  int n_chk = 0;
  int n_fail = 0;

  // bench model
  logic [7:0]  m_regs [8];
  logic [15:0] m_base;
  logic [3:0]  m_irq, m_dma;
  logic [19:0] m_rom;
  logic        m_trig = 1'b0;
  int          m_left = 0;

  always #4 clk = ~clk;  // 125 MHz

  pos_cfg_decoder #(.RESET_CYCLES(N)) dut (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)          m_left <= 0;
    else if (m_trig)     m_left <= N;
    else if (m_left > 0) m_left <= m_left - 1;
  end

  function automatic logic [15:0] exp_io(input logic [7:0] v);
    case (v & 8'hC7)
      8'h01: return 16'h0130;
      8'h02: return 16'h0230;
      8'h03: return 16'h0330;
      8'h41: return 16'h0134;
      8'h42: return 16'h0234;
      8'h43: return 16'h0334;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [19:0] exp_rom(input logic [7:0] v, input logic [19:0] old);
    case (v & 8'h38)
      8'h38: return 20'hDC000;
      8'h30: return 20'hD8000;
      8'h28: return 20'hD4000;
      8'h20: return 20'hD0000;
      8'h18: return 20'hCC000;
      8'h10: return 20'hC8000;
      default: return old;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_write(input logic [2:0] a, input logic [7:0] d);
    m_trig = 1'b0;
    if (a < 3'd2) return;
    m_regs[a] = d;
    if (m_regs[2][0]) begin
      m_base = exp_io(m_regs[3]);
      m_irq  = 4'((m_regs[4] & 8'h07) + 8'd8);
      m_dma  = m_regs[5][3:0];
      m_rom  = m_regs[2][7] ? 20'h0 : exp_rom(m_regs[3], m_rom);
    end
    m_trig = (m_base != 0) && (m_irq != 0) && (m_dma != 0);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    m_trig = 1'b0;
  endtask

  task automatic check_all(input string tag);
    chk("R3/R4", {tag, " io_base"}, 32'(io_base), 32'(m_base));
    chk("R5", {tag, " irq_num"}, 32'(irq_num), 32'(m_irq));
    chk("R5", {tag, " dma_chan"}, 32'(dma_chan), 32'(m_dma));
    chk("R6", {tag, " rom_base"}, 32'(rom_base), 32'(m_rom));
    chk("R10", {tag, " selftest"}, 32'(stat_selftest), 32'(m_left > 0));
    chk("R10", {tag, " idle"}, 32'(stat_idle), 32'(m_left == 0));
    for (int i = 0; i < 8; i++) begin
      rd_addr = 3'(i);
      #0.2;
      chk("R1", {tag, " readback"}, 32'(rd_data), 32'(m_regs[i]));
    end
    io_addr = (m_base != 0) ? 16'(m_base + 16'($urandom % 8) - 16'd2) : 16'($urandom);
    mem_addr = (m_rom != 0) ? 20'(m_rom + 20'h3FFE + 20'($urandom % 4)) : 20'($urandom);
    #0.2;
    chk("R7", {tag, " io_hit"}, 32'(io_hit),
        32'((m_base != 0) && io_addr >= m_base && io_addr <= m_base + 16'd3));
    chk("R8", {tag, " rom_hit"}, 32'(rom_hit),
        32'((m_rom != 0) && mem_addr >= m_rom && mem_addr <= m_rom + 20'h3FFF));
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] codes [6];
    codes = '{8'h01, 8'h02, 8'h03, 8'h41, 8'h42, 8'h43};
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) m_regs[i] = 8'h00;
    m_regs[0] = 8'h1F;
    m_base = '0; m_irq = '0; m_dma = '0; m_rom = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "reset io_base", 32'(io_base), 0);
    chk("R11", "reset rom_base", 32'(rom_base), 0);
    chk("R11", "reset selftest", 32'(stat_selftest), 0);
    chk("R11", "reset idle", 32'(stat_idle), 1);
    check_all("R11 reset");
    rd_addr = 3'd0; #0.2;
    chk("R2", "id byte", 32'(rd_data), 32'h1F);

    // R1 low offsets ignored
    do_write(3'd0, 8'hAA);
    do_write(3'd1, 8'h55);
    rd_addr = 3'd0; #0.2;
    chk("R2", "id after write", 32'(rd_data), 32'h1F);
    rd_addr = 3'd1; #0.2;
    chk("R1", "offset1 ignored", 32'(rd_data), 32'h00);
    chk("R1", "no reset from low offsets", 32'(stat_selftest), 0);

    // R3 no decode while card disabled
    do_write(3'd3, 8'h01);
    do_write(3'd4, 8'h05);
    do_write(3'd5, 8'h03);
    chk("R3", "held base while disabled", 32'(io_base), 0);
    check_all("R3 disabled");

    // R9 enable -> decode and reset start
    do_write(3'd2, 8'h01);
    chk("R4", "base 0x130", 32'(io_base), 32'h130);
    chk("R5", "irq 8+5", 32'(irq_num), 13);
    chk("R6", "rom code 0 holds", 32'(rom_base), 0);
    chk("R9", "selftest raised", 32'(stat_selftest), 1);
    chk("R9", "idle dropped", 32'(stat_idle), 0);
    repeat (N - 1) @(negedge clk);
    chk("R10", "selftest at last cycle", 32'(stat_selftest), 1);
    @(negedge clk);
    chk("R10", "selftest cleared", 32'(stat_selftest), 0);
    chk("R10", "idle set", 32'(stat_idle), 1);

    // R10 restart mid-interval
    do_write(3'd5, 8'h03);
    repeat (20) @(negedge clk);
    do_write(3'd4, 8'h02);
    repeat (N - 1) @(negedge clk);
    chk("R10", "restart keeps selftest", 32'(stat_selftest), 1);
    @(negedge clk);
    chk("R10", "restart ends", 32'(stat_selftest), 0);

    // R3 hold when enable cleared
    do_write(3'd2, 8'h00);
    do_write(3'd3, 8'h02);
    chk("R3", "base held after disable", 32'(io_base), 32'h130);
    check_all("R3 hold");

    // R4 table and R7 window edges
    do_write(3'd2, 8'h01);
    foreach (codes[k]) begin
      do_write(3'd3, codes[k] | 8'h38);
      check_all("R4 table");
      io_addr = m_base + 16'd3; #0.2;
      chk("R7", "top of io window", 32'(io_hit), 1);
      io_addr = m_base + 16'd4; #0.2;
      chk("R7", "past io window", 32'(io_hit), 0);
      io_addr = m_base - 16'd1; #0.2;
      chk("R7", "below io window", 32'(io_hit), 0);
    end
    do_write(3'd3, 8'h87);
    chk("R4", "unlisted code gives 0", 32'(io_base), 0);
    chk("R7", "no hit with base 0", 32'(io_hit), 0);

    // R6 rom decode, disable, hold
    do_write(3'd3, 8'h13);
    chk("R6", "rom code 2", 32'(rom_base), 32'hC8000);
    mem_addr = 20'hCBFFF; #0.2;
    chk("R8", "rom top byte", 32'(rom_hit), 1);
    mem_addr = 20'hCC000; #0.2;
    chk("R8", "past rom window", 32'(rom_hit), 0);
    do_write(3'd3, 8'h0B);
    chk("R6", "rom code 1 holds", 32'(rom_base), 32'hC8000);
    do_write(3'd2, 8'h81);
    chk("R6", "rom disabled", 32'(rom_base), 0);
    mem_addr = 20'hC8000; #0.2;
    chk("R8", "no rom hit when disabled", 32'(rom_hit), 0);

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom % 8);
      d = 8'($urandom);
      if (a == 3'd3 && ($urandom % 2) == 0)
        d = codes[$urandom % 6] | 8'(($urandom % 8) << 3);
      if (a == 3'd2) d = {d[7], 6'd0, (($urandom % 4) != 0)};
      do_write(a, d);
      check_all("random");
      if (($urandom % 10) == 0) begin
        repeat ($urandom % 60) @(negedge clk);
        check_all("random gap");
      end
    end

    finish_run();
  end
endmodule